// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port. Software reaches it through three registers on a small register bus:
- **Pin register**: the sampled pad levels.
- **Latch register**: the output values.
- **Direction register**: one bit per pin. A 1 makes the pin an input with its driver off. A 0 makes it an output.

The block drives an output enable and an output value per pin to tri-state pads. It samples the pad input levels through a two-flop synchronizer.

Other logic can take pins away from the port through per-pin control inputs:
- **Analog mode** makes a pin read as zero. Its driver stays under direction control.
- **Oscillator ownership** claims the top two pins. Those pins then read as zero in all three registers, are never driven, and ignore writes.
- **Segment override** on pins 2 to 5 turns the port function off for that pin.

Pin 4 is open-drain. It can only pull its pad low.

The register bus has no back-pressure. A write completes on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The analog-mode source sits outside this block. After reset it is expected to present bits 0 to 3 and bit 5 as analog (`analog_en = 8'h2F`), with bit 4 as a digital input.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, the latch register reads 8'h00 and no pad output enable is active.
- R2: A pin whose direction bit is 0 has `pad_oe` = 1 and `pad_out` equal to its latch bit. A pin whose direction bit is 1 has `pad_oe` = 0. Pin 4 follows R7 instead.
- R3: A write to address 0 (pin) or address 1 (latch) updates the output latch on that clock edge. Reading address 1 returns the latch value.
- R4: Reading address 0 returns the pad levels delayed by two clock edges. Reading address 1 returns the latch regardless of pad levels.
- R5: A pin with `analog_en` set reads as 0 at address 0. Its `pad_oe` still follows its direction bit.
- R6: While `osc_sel` = 1, bits 6 and 7 read as 0 at addresses 0, 1 and 2, and their `pad_oe` and `pad_out` are 0. Writes to those bits are ignored, so their stored values come back when `osc_sel` returns to 0.
- R7: Pin 4 is open-drain. `pad_out[4]` is always 0. `pad_oe[4]` is 1 only when its direction bit and its latch bit are both 0.
- R8: `seg_en` set on any of bits 2 to 5 forces that pin's `pad_oe` to 0 and its address-0 read to 0. `seg_en` on bits 0, 1, 6 and 7 has no effect.
- R9: Address 3 reads as 8'h00, and writes to it change no register.
- R10: `bus_rdata` follows `bus_addr` within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| analog_en | input | 8 | Per-pin analog mode |
| osc_sel | input | 1 | Oscillator owns pins 6 and 7 |
| seg_en | input | 8 | Per-pin segment override (bits 2 to 5 active) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `osc_sel` and `seg_en` are synchronous to `clk`. They also assume that the write-data checks see `osc_sel` steady across the write edge. Only `pad_in` may change at any time. The bench changes every control and bus input half a cycle away from the rising edge. It holds `osc_sel` and `seg_en` steady over each write, and it changes `pad_in` only while it waits for the synchronizer to settle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_async;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  hold_mask,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q
);
  logic lat_hit;
  logic dir_hit;

  assign lat_hit = wr && ((addr == SEL_PIN) || (addr == SEL_LAT));
  assign dir_hit = wr && (addr == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_hit) lat_q <= (wdata & ~hold_mask) | (lat_q & hold_mask);
      if (dir_hit) dir_q <= (wdata & ~hold_mask) | (dir_q & hold_mask);
    end
  end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned      WIDTH   = 8,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h10
) (
  input  logic [WIDTH-1:0] lat,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] taken,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (OD_MASK[i]) begin : g_od
      assign oe[i]  = !taken[i] && !dir[i] && !lat[i];
      assign out[i] = 1'b0;
    end else begin : g_push_pull
      assign oe[i]  = !taken[i] && !dir[i];
      assign out[i] = !taken[i] && lat[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OD_MASK     = 8'h10,
  parameter logic [WIDTH-1:0] OSC_MASK    = 8'hC0,
  parameter logic [WIDTH-1:0] SEG_MASK    = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  analog_en,
  input  logic              osc_sel,
  input  logic [WIDTH-1:0]  seg_en,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  logic [WIDTH-1:0] osc_own;
  logic [WIDTH-1:0] seg_own;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  assign osc_own = {WIDTH{osc_sel}} & OSC_MASK;
  assign seg_own = seg_en & SEG_MASK;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .hold_mask (osc_own),
    .lat_q     (lat_q),
    .dir_q     (dir_q)
  );

  gpio_pad_drv #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_drv (
    .lat   (lat_q),
    .dir   (dir_q),
    .taken (osc_own | seg_own),
    .oe    (pad_oe),
    .out   (pad_out)
  );

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_PIN: bus_rdata = pin_sync & ~(analog_en | osc_own | seg_own);
      SEL_LAT: bus_rdata = lat_q & ~osc_own;
      SEL_DIR: bus_rdata = dir_q & ~osc_own;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] OD_MASK  = 8'h10,
  parameter logic [WIDTH-1:0] OSC_MASK = 8'hC0,
  parameter logic [WIDTH-1:0] SEG_MASK = 8'h3C
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] analog_en,
  input logic             osc_sel,
  input logic [WIDTH-1:0] seg_en,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] dir_q
);
  a_r2_input_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr <= 2'd1) && !osc_sel)
      |=> ((lat_q & ~OSC_MASK) == ($past(bus_wdata) & ~OSC_MASK)));

  a_r5_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & analog_en) == '0));

  a_r6_osc_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    osc_sel |-> (((pad_oe | pad_out) & OSC_MASK) == '0));

  a_r6_osc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_sel && bus_wr) |=> ((lat_q & OSC_MASK) == ($past(lat_q) & OSC_MASK)));

  a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & OD_MASK) == '0);

  a_r8_seg_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & seg_en & SEG_MASK) == '0);

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .OD_MASK(OD_MASK), .OSC_MASK(OSC_MASK), .SEG_MASK(SEG_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .analog_en (analog_en),
  .osc_sel   (osc_sel),
  .seg_en    (seg_en),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .lat_q     (lat_q),
  .dir_q     (dir_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] analog_en = 8'h2F;
  logic       osc_sel = 1'b0;
  logic [7:0] seg_en = 8'h00;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .analog_en(analog_en),
    .osc_sel(osc_sel), .seg_en(seg_en), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd2, v); check("R1 dir after reset", v, 8'hFF);
    rd(2'd1, v); check("R1 latch after reset", v, 8'h00);
    check("R1 oe after reset", pad_oe, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    analog_en = 8'h00;
    wr(2'd0, 8'hA5);
    rd(2'd1, v); check("R3 pin write lands in latch", v, 8'hA5);
    check("R3 pads not driven while inputs", pad_oe, 8'h00);
    wr(2'd1, 8'h3C);
    rd(2'd1, v); check("R3 latch write", v, 8'h3C);
    bus_addr = 2'd2; #0.5;
    check("R10 comb read dir", bus_rdata, 8'hFF);
    bus_addr = 2'd1; #0.5;
    check("R10 comb read latch", bus_rdata, 8'h3C);
  endtask

  task automatic t_direction();
    wr(2'd2, 8'h00);
    #1;
    check("R2 oe all outputs (pin4 od high)", pad_oe, 8'hEF);
    check("R2 pad_out follows latch", pad_out, 8'h2C);
    wr(2'd2, 8'hF0);
    #1;
    check("R2 oe low nibble", pad_oe, 8'h0F);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    @(negedge clk); bus_addr = 2'd0; pad_in = 8'h5A;
    @(negedge clk); #1 check("R4 one edge not yet visible", bus_rdata, 8'h00);
    @(negedge clk); #1 check("R4 visible after two edges", bus_rdata, 8'h5A);
    rd(2'd1, v); check("R4 latch independent of pads", v, 8'h3C);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    analog_en = 8'h0F;
    rd(2'd0, v); check("R5 analog pins read zero", v, 8'h50);
    wr(2'd2, 8'hFE);
    #1 check("R5 analog pin still driven", pad_oe, 8'h01);
    analog_en = 8'h00;
  endtask

  task automatic t_osc();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    osc_sel = 1'b1; pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R6 pin top bits zero", v, 8'h3F);
    rd(2'd1, v); check("R6 latch top bits zero", v, 8'h3C);
    rd(2'd2, v); check("R6 dir top bits zero", v, 8'h3F);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    #1 check("R6 oe top bits off", pad_oe, 8'h2F);
    check("R6 out top bits off", pad_out, 8'h2F);
    @(negedge clk); osc_sel = 1'b0;
    rd(2'd1, v); check("R6 latch top kept after release", v, 8'h3F);
    rd(2'd2, v); check("R6 dir top kept after release", v, 8'hC0);
  endtask

  task automatic t_open_drain();
    wr(2'd1, 8'hEF);
    #1 check("R7 od pin pulls low", pad_oe, 8'h3F);
    check("R7 od out zero", pad_out, 8'hEF);
    wr(2'd1, 8'hFF);
    #1 check("R7 od pin released", pad_oe, 8'h2F);
    check("R7 od out still zero", pad_out, 8'hEF);
  endtask

  task automatic t_segment();
    logic [7:0] v;
    seg_en = 8'hFF;
    #1 check("R8 seg pins not driven", pad_oe, 8'h03);
    rd(2'd0, v); check("R8 seg pins read zero", v, 8'hC3);
    seg_en = 8'hC3;
    #1 check("R8 seg outside mask no effect oe", pad_oe, 8'h2F);
    rd(2'd0, v); check("R8 seg outside mask no effect read", v, 8'hFF);
    seg_en = 8'h00;
  endtask

  task automatic t_unused();
    logic [7:0] v;
    rd(2'd3, v); check("R9 unused reads zero", v, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd1, v); check("R9 latch unchanged", v, 8'hFF);
    rd(2'd2, v); check("R9 dir unchanged", v, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_direction();
    t_sync();
    t_analog();
    t_osc();
    t_open_drain();
    t_segment();
    t_unused();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule